// File: doc/BRIEF.md
# Dual-Mode Integration Period Sequencer

This block paces the integration windows of a converter that measures two photodiodes one after the other and later takes the difference of the two readings. It drives a diode-select line that chooses which diode is being integrated. It also counts oscillator ticks over each full two-phase measurement. When a measurement closes, it offers the elapsed tick count on a small valid/ready result port.

There are two timing modes. In internal mode, each diode phase lasts a fixed power-of-two number of ticks, chosen by a two-bit width field. In external mode, the host sends single-cycle sync pulses. Three pulses make up one measurement, and the count reports how many ticks passed between the first pulse and the third. The tick rate comes from one base clock through a tick enable. The two lower ranges tick at half rate and the two upper ranges tick at full rate. An enable field holds the sequencer in reset. A power-down field freezes it in place.

Result port rules:
- `res_valid` rises in the cycle after the edge that closes a measurement.
- `res_count` and `res_ovf` then stay stable until the consumer accepts them. A result is accepted at a clock edge where both `res_valid` and `res_ready` are high.
- There is no queue. If a new measurement closes while the old result is still unaccepted, the new result replaces it.
- If a measurement closes on the same edge as an acceptance, the new result is valid in the next cycle.

Top module: `intper_seq`

## Requirements
- R1: In internal mode (cfg_ext_mode = 0), each diode phase lasts 2^16, 2^12, 2^8 or 2^4 ticks for cfg_width codes 00, 01, 10 and 11. The published count is the total over both phases. It saturates at 65535 with res_ovf = 1, which happens for code 00.
- R2: cfg_ext_mode = 0 selects internal timing and cfg_ext_mode = 1 selects external timing from sync_pulse.
- R3: While cfg_enable = 0, the block stays in reset mode:
  - diode_sel and integ_active read 0;
  - res_valid is cleared;
  - sync pulses are ignored and no result is produced.
- R4: While cfg_enable = 1 and cfg_pwrdn = 1:
  - no tick is counted;
  - sync pulses are ignored;
  - the phase is held and no result is produced.
- R5: In external mode, the first sync pulse starts diode 1. The second sync pulse switches to diode 2. The third sync pulse closes the measurement, publishes it and starts diode 1 again.
- R6: In external mode, the count covers the ticks at the clock edges after the first sync edge, up to and including the third sync edge. It saturates at 65535 with res_ovf = 1 instead of wrapping. The next measurement starts again from zero with res_ovf = 0.
- R7: cfg_range codes 00 and 01 tick on every second clock cycle. Codes 10 and 11 tick on every cycle.
- R8: diode_sel = 0 means diode 1 and diode_sel = 1 means diode 2. Every measurement integrates diode 1 first.
- R9: A change of cfg_ext_mode or cfg_width restarts the sequence at diode 1 with the counters cleared. In external mode the restart then waits for a new first sync pulse. The interrupted measurement is never published.
- R10: res_valid rises in the cycle after the closing edge. The result then holds stable until accepted, and an unaccepted result is overwritten by the next one. When a close and an acceptance happen on the same edge, the new result is valid in the next cycle.
- R11: integ_active is 1 whenever a diode phase is in progress. In internal mode this is the case from one cycle after enable onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | 1 = run, 0 = hold in reset mode |
| cfg_pwrdn | input | 1 | 1 = freeze all activity |
| cfg_ext_mode | input | 1 | 0 = internal timing, 1 = external sync timing |
| cfg_width | input | 2 | Ticks per internal diode phase (00 longest, 11 shortest) |
| cfg_range | input | 2 | 00/01 half tick rate, 10/11 full tick rate |
| sync_pulse | input | 1 | Single-cycle host sync in external mode |
| diode_sel | output | 1 | 0 = diode 1, 1 = diode 2 |
| integ_active | output | 1 | A diode phase is in progress |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_count | output | 16 | Ticks in the closed measurement |
| res_ovf | output | 1 | Count saturated during that measurement |

## Verification
Two functions can land on the same clock edge: a measurement closing, and the consumer accepting the result that is still pending. The bench provokes this in external mode. It keeps `res_ready` low through one finished measurement. It then raises `res_ready` in the same cycle that carries the third sync pulse of the next measurement. The scoreboard must see both results in order: the old one accepted at that edge, and the new one valid in the very next cycle. A second run leaves `res_ready` low through both measurements and expects only the later one, which shows that the newer result overwrites the older.

// File: rtl/intper_pkg.sv
package intper_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_D1   = 2'd1,
    PH_D2   = 2'd2
  } phase_t;
endpackage

// File: rtl/intper_tick.sv
// Tick enable: full rate for the upper ranges, one tick per two cycles for
// the lower ranges. The divider phase only advances while running.
module intper_tick (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] range_sel,
  output logic       tick
);
  logic half_ph;
  logic full_rate;

  assign full_rate = (range_sel >= 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    half_ph <= 1'b0;
    else if (!run) half_ph <= 1'b0;
    else           half_ph <= ~half_ph;
  end

  assign tick = run & (full_rate | half_ph);
endmodule

// File: rtl/intper_phase.sv
// Phase sequencer: idle / diode 1 / diode 2, internal or external pacing.
module intper_phase
  import intper_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int STEP_LOG = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       run,
  input  logic       restart,
  input  logic       ext_mode,
  input  logic [1:0] width,
  input  logic       tick,
  input  logic       sync_pulse,
  output phase_t     phase,
  output logic       publish,
  output logic       cnt_en,
  output logic       cnt_clr
);
  logic [CNT_W-1:0] pc, pc_n, lim;
  phase_t           nxt;
  logic             last_tick;

  function automatic logic [CNT_W-1:0] lim_of(input logic [1:0] code);
    int sh;
    logic [CNT_W:0] full;
    sh   = CNT_W - STEP_LOG * int'(code);
    full = ((CNT_W+1)'(1) << sh) - (CNT_W+1)'(1);
    return full[CNT_W-1:0];
  endfunction

  assign lim       = lim_of(width);
  assign last_tick = tick && (pc == lim);

  always_comb begin
    nxt     = phase;
    pc_n    = pc;
    publish = 1'b0;
    if (!enable) begin
      nxt  = PH_IDLE;
      pc_n = '0;
    end else if (restart) begin
      nxt  = ext_mode ? PH_IDLE : PH_D1;
      pc_n = '0;
    end else if (run) begin
      unique case (phase)
        PH_IDLE: begin
          if (!ext_mode || sync_pulse) nxt = PH_D1;
        end
        PH_D1: begin
          if (ext_mode) begin
            if (sync_pulse) nxt = PH_D2;
          end else if (last_tick) begin
            nxt  = PH_D2;
            pc_n = '0;
          end else if (tick) begin
            pc_n = pc + 1'b1;
          end
        end
        PH_D2: begin
          if (ext_mode) begin
            if (sync_pulse) begin
              nxt     = PH_D1;
              publish = 1'b1;
            end
          end else if (last_tick) begin
            nxt     = PH_D1;
            pc_n    = '0;
            publish = 1'b1;
          end else if (tick) begin
            pc_n = pc + 1'b1;
          end
        end
        default: nxt = PH_IDLE;
      endcase
    end
  end

  assign cnt_clr = !enable || restart || (phase == PH_IDLE);
  assign cnt_en  = run && tick && !cnt_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      pc    <= '0;
    end else begin
      phase <= nxt;
      pc    <= pc_n;
    end
  end
endmodule

// File: rtl/intper_timer.sv
// Saturating measurement tick counter with sticky overflow.
module intper_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cnt_en,
  input  logic             publish,
  output logic [CNT_W-1:0] cnt_now,
  output logic             ovf_now
);
  logic [CNT_W-1:0] cnt;
  logic             ovf;
  logic             at_top;

  assign at_top  = (cnt == {CNT_W{1'b1}});
  assign cnt_now = (cnt_en && !at_top) ? cnt + 1'b1 : cnt;
  assign ovf_now = ovf | (cnt_en & at_top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (clr || publish) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (cnt_en) begin
      cnt <= cnt_now;
      ovf <= ovf_now;
    end
  end
endmodule

// File: rtl/intper_outreg.sv
// Single-entry result holder with valid/ready; newer results overwrite.
module intper_outreg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             publish,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             ovf_in,
  input  logic             ready,
  output logic             valid,
  output logic [CNT_W-1:0] cnt_out,
  output logic             ovf_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      cnt_out <= '0;
      ovf_out <= 1'b0;
    end else if (!enable) begin
      valid <= 1'b0;
    end else if (publish) begin
      valid   <= 1'b1;
      cnt_out <= cnt_in;
      ovf_out <= ovf_in;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/intper_seq.sv
module intper_seq
  import intper_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int STEP_LOG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_pwrdn,
  input  logic             cfg_ext_mode,
  input  logic [1:0]       cfg_width,
  input  logic [1:0]       cfg_range,
  input  logic             sync_pulse,
  output logic             diode_sel,
  output logic             integ_active,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [CNT_W-1:0] res_count,
  output logic             res_ovf
);
  logic             run;
  logic             tick;
  logic             restart;
  logic             publish;
  logic             cnt_en;
  logic             cnt_clr;
  logic [CNT_W-1:0] cnt_now;
  logic             ovf_now;
  logic             prev_mode;
  logic [1:0]       prev_width;
  phase_t           phase;

  assign run = cfg_enable && !cfg_pwrdn;

  // Configuration change detection: any mode or width edit restarts.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_mode  <= 1'b0;
      prev_width <= 2'b00;
    end else begin
      prev_mode  <= cfg_ext_mode;
      prev_width <= cfg_width;
    end
  end
  assign restart = (cfg_ext_mode != prev_mode) || (cfg_width != prev_width);

  intper_tick u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .range_sel (cfg_range),
    .tick      (tick)
  );

  intper_phase #(.CNT_W(CNT_W), .STEP_LOG(STEP_LOG)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (cfg_enable),
    .run        (run),
    .restart    (restart),
    .ext_mode   (cfg_ext_mode),
    .width      (cfg_width),
    .tick       (tick),
    .sync_pulse (sync_pulse),
    .phase      (phase),
    .publish    (publish),
    .cnt_en     (cnt_en),
    .cnt_clr    (cnt_clr)
  );

  intper_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cnt_clr),
    .cnt_en  (cnt_en),
    .publish (publish),
    .cnt_now (cnt_now),
    .ovf_now (ovf_now)
  );

  intper_outreg #(.CNT_W(CNT_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (cfg_enable),
    .publish (publish),
    .cnt_in  (cnt_now),
    .ovf_in  (ovf_now),
    .ready   (res_ready),
    .valid   (res_valid),
    .cnt_out (res_count),
    .ovf_out (res_ovf)
  );

  assign diode_sel    = (phase == PH_D2);
  assign integ_active = (phase != PH_IDLE);
endmodule

// File: rtl/intper_seq_chk.sv
module intper_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_enable,
  input logic             cfg_pwrdn,
  input logic             cfg_ext_mode,
  input logic [1:0]       cfg_width,
  input logic [1:0]       cfg_range,
  input logic             sync_pulse,
  input logic             diode_sel,
  input logic             integ_active,
  input logic             res_valid,
  input logic             res_ready,
  input logic [CNT_W-1:0] res_count,
  input logic             res_ovf,
  input logic             tick,
  input logic             publish
);
  // R3
  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (!diode_sel && !integ_active && !res_valid));

  // R4
  a_r4_pwrdn_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && cfg_pwrdn && $stable(cfg_ext_mode) && $stable(cfg_width))
    |=> ($stable(diode_sel) && $stable(integ_active)));

  // R5
  a_r5_ext_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && cfg_ext_mode && !sync_pulse && $stable(cfg_ext_mode) && $stable(cfg_width))
    |=> $stable(diode_sel));

  // R6
  a_r6_ovf_saturated: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ovf) |-> (res_count == {CNT_W{1'b1}}));

  // R7
  a_r7_half_rate_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cfg_range < 2'd2) |=> (!tick || cfg_range >= 2'd2));

  // R8
  a_r8_sel_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
    diode_sel |-> integ_active);

  // R10
  a_r10_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && !publish && cfg_enable)
    |=> (res_valid && $stable(res_count) && $stable(res_ovf)));

  a_r10_valid_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    publish |=> res_valid);

  // R11
  a_r11_internal_stays_active: assert property (@(posedge clk) disable iff (!rst_n)
    (integ_active && cfg_enable && !cfg_ext_mode) |=> integ_active);
endmodule

bind intper_seq intper_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_enable   (cfg_enable),
  .cfg_pwrdn    (cfg_pwrdn),
  .cfg_ext_mode (cfg_ext_mode),
  .cfg_width    (cfg_width),
  .cfg_range    (cfg_range),
  .sync_pulse   (sync_pulse),
  .diode_sel    (diode_sel),
  .integ_active (integ_active),
  .res_valid    (res_valid),
  .res_ready    (res_ready),
  .res_count    (res_count),
  .res_ovf      (res_ovf),
  .tick         (tick),
  .publish      (publish)
);

// File: tb/intper_seq_test.sv
`timescale 1ns/1ps
module intper_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic        cfg_pwrdn = 1'b0;
  logic        cfg_ext_mode = 1'b0;
  logic [1:0]  cfg_width = 2'b11;
  logic [1:0]  cfg_range = 2'b10;
  logic        sync_pulse = 1'b0;
  logic        res_ready = 1'b1;
  logic        diode_sel, integ_active, res_valid, res_ovf;
  logic [15:0] res_count;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [16:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  intper_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_pwrdn(cfg_pwrdn),
    .cfg_ext_mode(cfg_ext_mode), .cfg_width(cfg_width), .cfg_range(cfg_range),
    .sync_pulse(sync_pulse), .diode_sel(diode_sel), .integ_active(integ_active),
    .res_valid(res_valid), .res_ready(res_ready), .res_count(res_count), .res_ovf(res_ovf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input string tag, input logic [15:0] cnt, input logic ovf);
    exp_q.push_back({ovf, cnt});
    tag_q.push_back(tag);
  endtask

  // Monitor: pops one expected item per accepted result.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && res_valid && res_ready) begin
        if (exp_q.size() == 0) begin
          chk("R10 unexpected result", {15'd0, res_ovf, res_count}, 32'hFFFF_FFFF);
        end else begin
          logic [16:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({t, " count"}, {16'd0, res_count}, {16'd0, e[15:0]});
          chk({t, " ovf"}, {31'd0, res_ovf}, {31'd0, e[16]});
        end
      end
    end
  end

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    #2;
  endtask

  task automatic sync_gap(input int g);
    @(negedge clk); sync_pulse = 1'b1;
    @(negedge clk); sync_pulse = 1'b0;
    repeat (g - 2) @(negedge clk);
  endtask

  task automatic sync_once();
    @(negedge clk); sync_pulse = 1'b1;
    @(negedge clk); sync_pulse = 1'b0;
  endtask

  task automatic start(input logic ext, input logic [1:0] w, input logic [1:0] r);
    @(negedge clk);
    cfg_enable = 1'b0;
    cfg_ext_mode = ext; cfg_width = w; cfg_range = r;
    @(negedge clk);
    @(negedge clk);
    cfg_enable = 1'b1;
  endtask

  task automatic stop();
    cfg_enable = 1'b0;
    res_ready = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk("watchdog expired", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic s0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R3 reset valid", {31'd0, res_valid}, 0);
    chk("R3 reset diode_sel", {31'd0, diode_sel}, 0);
    chk("R3 reset active", {31'd0, integ_active}, 0);

    // Internal, code 11, full rate: 16 ticks per phase, 32 per measurement.
    start(1'b0, 2'b11, 2'b10);
    push("R1 R2 int w11", 16'd32, 1'b0);
    push("R1 int w11 second", 16'd32, 1'b0);
    repeat (10) @(negedge clk); #1;
    chk("R8 diode1 first", {31'd0, diode_sel}, 0);
    chk("R11 active internal", {31'd0, integ_active}, 1);
    repeat (10) @(negedge clk); #1;
    chk("R8 diode2 second", {31'd0, diode_sel}, 1);
    drain(); stop();

    // Internal, code 10, half rate: 512 ticks over 1024 cycles.
    start(1'b0, 2'b10, 2'b00);
    push("R7 int w10 half", 16'd512, 1'b0);
    drain(); stop();

    // Internal, code 01, full rate.
    start(1'b0, 2'b01, 2'b11);
    push("R1 int w01", 16'd8192, 1'b0);
    drain(); stop();

    // Power-down freezes an internal measurement.
    start(1'b0, 2'b11, 2'b10);
    push("R4 int after pwrdn", 16'd32, 1'b0);
    repeat (8) @(negedge clk);
    cfg_pwrdn = 1'b1;
    #1 s0 = diode_sel;
    repeat (40) @(negedge clk); #1;
    chk("R4 phase held", {31'd0, diode_sel}, {31'd0, s0});
    chk("R4 no result", {31'd0, res_valid}, 0);
    cfg_pwrdn = 1'b0;
    drain(); stop();

    // Width change restarts at diode 1.
    start(1'b0, 2'b11, 2'b10);
    repeat (20) @(negedge clk); #1;
    chk("R9 in diode2 before", {31'd0, diode_sel}, 1);
    cfg_width = 2'b10;
    push("R9 restart w10", 16'd512, 1'b0);
    @(negedge clk); #1;
    chk("R9 back to diode1", {31'd0, diode_sel}, 0);
    drain(); stop();

    // External, full rate.
    start(1'b1, 2'b11, 2'b10);
    push("R5 R6 ext full", 16'd150, 1'b0);
    #1 chk("R5 idle before sync", {31'd0, integ_active}, 0);
    sync_gap(100); #1;
    chk("R5 diode1 after sync1", {30'd0, integ_active, diode_sel}, 32'd2);
    sync_gap(50); #1;
    chk("R5 diode2 after sync2", {31'd0, diode_sel}, 1);
    sync_once();
    drain();
    chk("R5 diode1 after sync3", {30'd0, integ_active, diode_sel}, 32'd2);
    stop();

    // External, half rate.
    start(1'b1, 2'b11, 2'b01);
    push("R7 ext half", 16'd80, 1'b0);
    sync_gap(100); sync_gap(60); sync_once();
    drain(); stop();

    // Power-down ignores a sync.
    start(1'b1, 2'b11, 2'b10);
    cfg_pwrdn = 1'b1;
    sync_once();
    cfg_pwrdn = 1'b0;
    #1 chk("R4 sync ignored", {31'd0, integ_active}, 0);
    stop();

    // Disabled ignores syncs.
    cfg_ext_mode = 1'b1;
    sync_gap(10); sync_gap(10); sync_once();
    #1 chk("R3 disabled active", {31'd0, integ_active}, 0);
    chk("R3 disabled valid", {31'd0, res_valid}, 0);

    // Saturation, then a fresh measurement.
    start(1'b1, 2'b11, 2'b10);
    push("R6 saturate", 16'hFFFF, 1'b1);
    push("R6 after saturate", 16'd20, 1'b0);
    sync_gap(35000); sync_gap(35000); sync_gap(10); sync_gap(10); sync_once();
    drain(); stop();

    // Back-pressure: the newer result overwrites the unaccepted one.
    start(1'b1, 2'b11, 2'b10);
    res_ready = 1'b0;
    sync_gap(20); sync_gap(20); sync_gap(30); sync_gap(30); sync_once();
    repeat (3) @(negedge clk); #1;
    chk("R10 held valid", {31'd0, res_valid}, 1);
    chk("R10 overwritten", {16'd0, res_count}, 32'd60);
    repeat (5) @(negedge clk); #1;
    chk("R10 still held", {16'd0, res_count}, 32'd60);
    push("R10 accept held", 16'd60, 1'b0);
    res_ready = 1'b1;
    drain(); stop();

    // Close and acceptance on the same edge.
    start(1'b1, 2'b11, 2'b10);
    res_ready = 1'b0;
    push("R10 coincide old", 16'd40, 1'b0);
    push("R10 coincide new", 16'd60, 1'b0);
    sync_gap(20); sync_gap(20); sync_gap(30); sync_gap(30);
    @(negedge clk); sync_pulse = 1'b1; res_ready = 1'b1;
    @(negedge clk); sync_pulse = 1'b0;
    drain(); stop();

    finish_run();
  end
endmodule